// File: doc/BRIEF.md
# Context-Overloaded Register Microcontroller Core

A small multi-cycle processor core that runs one instruction at a time through fetch, execute and (for loads and stores) a memory step. It decodes four 16-bit instruction formats: store, load, add-immediate and a register-register operate. The register operate hands its op field and two operands to an ALU function block outside the core, which is combinational, and writes back whatever that block returns. The core has one memory port shared by instruction fetch and data access. Every request on that port is held until the memory answers with a ready strobe.

There is no dedicated branch instruction. Register index zero stands for the program counter or for the constant zero, depending on where it appears. Any write to index zero lands in the program counter. When register zero is used as the base of a load or add-immediate, it reads as the program counter. In every other operand position it reads as zero. From these rules come PC-relative branches, indexed jumps, returns through a link register, and a call that loads its target from the word right after the instruction.

The program counter, when read as an operand, holds the address of the word after the current instruction. The call sequence is therefore:
1. `IMMED link,0,2` stores the return address in the link register.
2. `LOAD 0,0,0` loads the program counter from the word that follows.
3. That following word holds the target address.

The matching return is `IMMED 0,link,0`.

Top module: `ctxreg_core`

## Requirements
- R1: Instruction words are 16 bits. The format is in bits [15:14]: 00 store, 01 load, 10 add-immediate, 11 operate. The fields are r in [13:11], x in [10:8] and a sign-extended displacement in [7:0]. An operate instruction carries its op in [7:3] and its second source d in [2:0].
- R2: After reset the program counter is 0 and registers 1 to 7 hold 0. The first request is a read of address 0 with no write strobe.
- R3: The program counter, when read as an operand, equals the fetched instruction's address plus one.
- R4: Add-immediate writes R[r] = base + disp. The base is the program counter when x = 0, otherwise R[x].
- R5: Add-immediate or load with r = 0 writes the program counter, and execution continues from the new value.
- R6: Load writes R[r] = M[base + disp]. The base is the program counter when x = 0, otherwise R[x].
- R7: Store writes M[R[x] + disp] = R[r]. For a store, x = 0 gives a base of zero and r = 0 gives data of zero.
- R8: Operate presents the op field on alu_fn, R[x] on alu_a and R[d] on alu_b, with index 0 reading as zero, and writes alu_y to R[r].
- R9: Read and write strobes are never active together. Once raised, a strobe stays active with its address and write data unchanged until the cycle in which mem_rdy is sampled high.
- R10: The sequence `IMMED L,0,2`, `LOAD 0,0,0`, followed by a target word, transfers control to the target with the return address in R[L]. `IMMED 0,L,0` then resumes at that return address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 16 | Word address for fetch or data access |
| mem_wdata | output | 16 | Store data |
| mem_rdata | input | 16 | Read data, valid when mem_rdy is high |
| mem_rd | output | 1 | Read request (fetch or load) |
| mem_wr | output | 1 | Write request (store) |
| mem_rdy | input | 1 | Memory completes the current request |
| alu_fn | output | 5 | Op field passed to the external ALU block |
| alu_a | output | 16 | First ALU operand, R[x] |
| alu_b | output | 16 | Second ALU operand, R[d] |
| alu_y | input | 16 | Result from the external ALU block |

## Verification
The bench sweeps all 256 displacements through add-immediate with a PC base and with a register base. This exposes a core that does not sign-extend, or that reads the program counter as the current instruction's address rather than the next one: every stored result would be off by a constant or would wrap the wrong way. It runs every op code against several operand pairs, with index-zero operands and a store of register zero. A core that read index zero as the program counter in those positions would leak address values into the results. Branch-skip and call/return programs show whether writes to index zero redirect the fetch stream. A reset run after registers have been dirtied would expose a register file that is not cleared. The memory model inserts wait states and records any request that changes before it is granted.

// File: rtl/ctxreg_pkg.sv
package ctxreg_pkg;
  localparam int WORD_W   = 16;
  localparam int RIDX_W   = 3;
  localparam int NUM_REGS = 1 << RIDX_W;
  localparam int DISP_W   = 8;
  localparam int OPF_W    = 5;
  localparam int FMT_W    = 2;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [RIDX_W-1:0] ridx_t;

  typedef enum logic [FMT_W-1:0] {
    FMT_STORE = 2'b00,
    FMT_LOAD  = 2'b01,
    FMT_IMMED = 2'b10,
    FMT_OPER  = 2'b11
  } fmt_e;

  typedef enum logic [1:0] {
    ST_FETCH = 2'd0,
    ST_EXEC  = 2'd1,
    ST_MEM   = 2'd2
  } state_e;

  typedef struct packed {
    fmt_e             fmt;
    ridx_t            r;
    ridx_t            x;
    ridx_t            d;
    logic [OPF_W-1:0] fn;
    word_t            disp;
  } instr_t;

  function automatic word_t sext_disp(input logic [DISP_W-1:0] v);
    return {{(WORD_W-DISP_W){v[DISP_W-1]}}, v};
  endfunction

  function automatic word_t addr_sum(input word_t base, input word_t off);
    return base + off;
  endfunction

  function automatic word_t next_pc(input word_t pc);
    return pc + word_t'(1);
  endfunction
endpackage

// File: rtl/ctxreg_decode.sv
module ctxreg_decode
  import ctxreg_pkg::*;
(
  input  word_t  ir,
  output instr_t dec
);
  localparam int FMT_LO = WORD_W - FMT_W;
  localparam int R_LO   = FMT_LO - RIDX_W;
  localparam int X_LO   = R_LO - RIDX_W;
  localparam int FN_LO  = RIDX_W;

  always_comb begin
    dec.fmt  = fmt_e'(ir[WORD_W-1:FMT_LO]);
    dec.r    = ir[FMT_LO-1:R_LO];
    dec.x    = ir[R_LO-1:X_LO];
    dec.d    = ir[RIDX_W-1:0];
    dec.fn   = ir[FN_LO+OPF_W-1:FN_LO];
    dec.disp = sext_disp(ir[DISP_W-1:0]);
  end
endmodule

// File: rtl/ctxreg_regfile.sv
module ctxreg_regfile #(
  parameter int NUM_REGS = 8,
  parameter int WIDTH    = 16,
  parameter int RD_PORTS = 3,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [IDX_W-1:0]                wr_idx,
  input  logic [WIDTH-1:0]                wr_data,
  input  logic [RD_PORTS-1:0][IDX_W-1:0]  rd_idx,
  output logic [RD_PORTS-1:0][WIDTH-1:0]  rd_val
);
  // entry 0 is never written and reads as zero
  logic [WIDTH-1:0] regs_q [NUM_REGS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= '0;
    end else begin
      for (int i = 1; i < NUM_REGS; i++)
        if (wr_en && wr_idx == IDX_W'(i)) regs_q[i] <= wr_data;
    end
  end

  for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
    assign rd_val[p] = regs_q[rd_idx[p]];
  end

  // R5
  no_r0_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_idx != '0);
endmodule

// File: rtl/ctxreg_core.sv
module ctxreg_core
  import ctxreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              mem_rd,
  output logic              mem_wr,
  input  logic              mem_rdy,
  output logic [OPF_W-1:0]  alu_fn,
  output logic [WORD_W-1:0] alu_a,
  output logic [WORD_W-1:0] alu_b,
  input  logic [WORD_W-1:0] alu_y
);
  localparam int RD_PORTS = 3;
  localparam int PX = 0;
  localparam int PD = 1;
  localparam int PR = 2;

  state_e state_q;
  word_t  pc_q, ir_q, ea_q, sd_q;
  instr_t dec;

  logic [RD_PORTS-1:0][RIDX_W-1:0] rf_idx;
  logic [RD_PORTS-1:0][WORD_W-1:0] rf_val;

  // named internal events
  logic  fetch_done, mem_done, in_exec, is_memop;
  logic  base_is_pc;
  word_t base_v, eff_v;
  logic  wb_en, wb_pc, rf_we;
  word_t wb_val;

  ctxreg_decode u_dec (.ir(ir_q), .dec(dec));

  assign rf_idx[PX] = dec.x;
  assign rf_idx[PD] = dec.d;
  assign rf_idx[PR] = dec.r;

  ctxreg_regfile #(
    .NUM_REGS(NUM_REGS), .WIDTH(WORD_W), .RD_PORTS(RD_PORTS)
  ) u_rf (
    .clk(clk), .rst_n(rst_n),
    .wr_en(rf_we), .wr_idx(dec.r), .wr_data(wb_val),
    .rd_idx(rf_idx), .rd_val(rf_val)
  );

  assign fetch_done = (state_q == ST_FETCH) && mem_rdy;
  assign mem_done   = (state_q == ST_MEM) && mem_rdy;
  assign in_exec    = (state_q == ST_EXEC);
  assign is_memop   = (dec.fmt == FMT_LOAD) || (dec.fmt == FMT_STORE);

  // index zero as base means PC for load and immediate, zero elsewhere
  assign base_is_pc = ((dec.fmt == FMT_LOAD) || (dec.fmt == FMT_IMMED)) && (dec.x == '0);
  assign base_v     = base_is_pc ? pc_q : rf_val[PX];
  assign eff_v      = addr_sum(base_v, dec.disp);

  assign alu_fn = dec.fn;
  assign alu_a  = rf_val[PX];
  assign alu_b  = rf_val[PD];

  always_comb begin
    wb_en  = 1'b0;
    wb_val = eff_v;
    if (in_exec && dec.fmt == FMT_IMMED) begin
      wb_en  = 1'b1;
      wb_val = eff_v;
    end else if (in_exec && dec.fmt == FMT_OPER) begin
      wb_en  = 1'b1;
      wb_val = alu_y;
    end else if (mem_done && dec.fmt == FMT_LOAD) begin
      wb_en  = 1'b1;
      wb_val = mem_rdata;
    end
  end

  assign wb_pc = wb_en && (dec.r == '0);
  assign rf_we = wb_en && (dec.r != '0);

  assign mem_rd    = (state_q == ST_FETCH) || ((state_q == ST_MEM) && dec.fmt == FMT_LOAD);
  assign mem_wr    = (state_q == ST_MEM) && (dec.fmt == FMT_STORE);
  assign mem_addr  = (state_q == ST_MEM) ? ea_q : pc_q;
  assign mem_wdata = sd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FETCH;
      pc_q    <= '0;
      ir_q    <= '0;
      ea_q    <= '0;
      sd_q    <= '0;
    end else begin
      if (wb_pc)           pc_q <= wb_val;
      else if (fetch_done) pc_q <= next_pc(pc_q);
      case (state_q)
        ST_FETCH: if (mem_rdy) begin
          ir_q    <= mem_rdata;
          state_q <= ST_EXEC;
        end
        ST_EXEC: begin
          if (is_memop) begin
            ea_q    <= eff_v;
            sd_q    <= rf_val[PR];
            state_q <= ST_MEM;
          end else begin
            state_q <= ST_FETCH;
          end
        end
        ST_MEM: if (mem_rdy) state_q <= ST_FETCH;
        default: state_q <= ST_FETCH;
      endcase
    end
  end

  // R9
  excl_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !mem_rdy) |=> (mem_rd && $stable(mem_addr)));
  // R9
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && !mem_rdy) |=> (mem_wr && $stable(mem_addr) && $stable(mem_wdata)));
  // R3
  fetch_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_done |=> (pc_q == $past(pc_q) + word_t'(1)));
  // R5
  pc_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_pc |=> (mem_rd && mem_addr == $past(wb_val)));
  // R8
  zero_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_exec && dec.fmt == FMT_OPER && dec.x == '0) |-> (alu_a == '0));
endmodule

// File: tb/ctxreg_core_tb.sv
module ctxreg_core_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_rd, mem_wr, mem_rdy;
  logic [4:0]  alu_fn;
  logic [15:0] alu_a, alu_b, alu_y;

  logic [15:0] mem [256];
  int lat_cfg = 0;
  int hs_bad = 0;
  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  function automatic logic [15:0] alu_model(input logic [4:0] f, input logic [15:0] a, input logic [15:0] b);
    logic [15:0] y;
    case (f[2:0])
      3'd0: y = a + b;
      3'd1: y = a - b;
      3'd2: y = a & b;
      3'd3: y = a | b;
      3'd4: y = a ^ b;
      3'd5: y = a << 1;
      3'd6: y = ~a;
      default: y = b;
    endcase
    return y ^ {f, 11'b0};
  endfunction

  assign alu_y = alu_model(alu_fn, alu_a, alu_b);

  ctxreg_core dut_i (
    .clk(clk), .rst_n(rst_n),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_rdy(mem_rdy),
    .alu_fn(alu_fn), .alu_a(alu_a), .alu_b(alu_b), .alu_y(alu_y)
  );

  // encodings per R1
  function automatic logic [15:0] enc(input logic [1:0] f, input logic [2:0] r, input logic [2:0] x, input logic [7:0] disp);
    return {f, r, x, disp};
  endfunction
  function automatic logic [15:0] enc_op(input logic [2:0] r, input logic [2:0] x, input logic [4:0] op, input logic [2:0] d);
    return {2'b11, r, x, op, d};
  endfunction
  localparam logic [1:0] F_ST = 2'b00, F_LD = 2'b01, F_IM = 2'b10;

  // memory model: serves requests at the falling edge, with lat_cfg wait cycles
  initial begin
    int cnt;
    logic [15:0] q_addr, q_wdata;
    logic q_wr;
    cnt = 0; q_addr = '0; q_wdata = '0; q_wr = 0;
    mem_rdy = 0; mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        mem_rdy = 0; cnt = 0;
      end else if (mem_rd || mem_wr) begin
        if (mem_rd && mem_wr) hs_bad++;
        if (cnt > 0 && (mem_addr != q_addr || mem_wr != q_wr || (mem_wr && mem_wdata != q_wdata))) hs_bad++;
        if (cnt == 0) begin q_addr = mem_addr; q_wr = mem_wr; q_wdata = mem_wdata; end
        if (cnt >= lat_cfg) begin
          mem_rdy = 1;
          mem_rdata = mem[mem_addr[7:0]];
          if (mem_wr) mem[mem_addr[7:0]] = mem_wdata;
          cnt = 0;
        end else begin
          mem_rdy = 0;
          cnt++;
        end
      end else begin
        mem_rdy = 0; cnt = 0;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_mem(input logic [15:0] fill);
    for (int i = 0; i < 256; i++) mem[i] = fill;
  endtask

  task automatic run_prog(input int lat, input int ncyc);
    lat_cfg = lat;
    hs_bad = 0;
    rst_n = 0;
    repeat (2) @(posedge clk);
    #2 rst_n = 1;
    repeat (ncyc) @(posedge clk);
    #3;
    check(hs_bad == 0, "R9 handshake held until ready", hs_bad, 0);
  endtask

  initial begin
    // watchdog
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc >= 190000 && !done) begin
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected<190000", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
      end
    end
  end

  initial begin
    logic [15:0] s, e;
    clear_mem(16'h0);

    // R4 R3: add-immediate sweep over every displacement, PC base then register base
    for (int dv = 0; dv < 256; dv++) begin
      clear_mem(16'h0);
      mem[0] = enc(F_IM, 3'd1, 3'd0, dv[7:0]);
      mem[1] = enc(F_ST, 3'd1, 3'd0, 8'h40);
      mem[2] = enc(F_IM, 3'd2, 3'd1, dv[7:0]);
      mem[3] = enc(F_ST, 3'd2, 3'd0, 8'h41);
      mem[4] = enc(F_IM, 3'd0, 3'd0, 8'hFF);
      run_prog(0, 40);
      s = {{8{dv[7]}}, dv[7:0]};
      e = 16'd1 + s;
      check(mem[64] == e, "R3 R4 immed with PC base", mem[64], e);
      e = 16'd1 + s + s;
      check(mem[65] == e, "R4 immed with register base", mem[65], e);
    end

    // R8 R6 R7 R1: operate sweep over all op codes and several operand pairs
    for (int pi = 0; pi < 4; pi++) begin
      logic [15:0] a, b;
      case (pi)
        0: begin a = 16'h1234; b = 16'h0F0F; end
        1: begin a = 16'hFFFF; b = 16'h0001; end
        2: begin a = 16'h8000; b = 16'h8000; end
        default: begin a = 16'h0000; b = 16'h7FFF; end
      endcase
      for (int op = 0; op < 32; op++) begin
        clear_mem(16'h0);
        mem[0] = enc(F_LD, 3'd1, 3'd0, 8'd9);
        mem[1] = enc(F_LD, 3'd2, 3'd0, 8'd9);
        mem[2] = enc_op(3'd3, 3'd1, op[4:0], 3'd2);
        mem[3] = enc(F_ST, 3'd3, 3'd0, 8'h40);
        mem[4] = enc_op(3'd4, 3'd0, op[4:0], 3'd0);
        mem[5] = enc(F_ST, 3'd4, 3'd0, 8'h41);
        mem[6] = enc(F_ST, 3'd0, 3'd0, 8'h42);
        mem[7] = enc(F_IM, 3'd0, 3'd0, 8'hFF);
        mem[10] = a;
        mem[11] = b;
        mem[66] = 16'hDEAD;
        run_prog((op + pi) % 3, 80);
        e = alu_model(op[4:0], a, b);
        check(mem[64] == e, "R1 R6 R8 operate on loaded operands", mem[64], e);
        e = alu_model(op[4:0], 16'h0, 16'h0);
        check(mem[65] == e, "R8 index zero operands read zero", mem[65], e);
        check(mem[66] == 16'h0, "R7 store of index zero writes zero", mem[66], 0);
      end
    end

    // R6 R7: register base with negative displacement
    clear_mem(16'h0);
    mem[0] = enc(F_IM, 3'd5, 3'd0, 8'h50);
    mem[1] = enc(F_ST, 3'd5, 3'd5, 8'hFD);
    mem[2] = enc(F_LD, 3'd4, 3'd5, 8'hFD);
    mem[3] = enc(F_ST, 3'd4, 3'd0, 8'h40);
    mem[4] = enc(F_IM, 3'd0, 3'd0, 8'hFF);
    run_prog(1, 80);
    check(mem[78] == 16'd81, "R7 store at register base minus three", mem[78], 81);
    check(mem[64] == 16'd81, "R6 load from register base minus three", mem[64], 81);

    // R5: PC-relative forward branch skips two words
    clear_mem(16'h0);
    mem[0] = enc(F_IM, 3'd0, 3'd0, 8'd2);
    mem[1] = enc(F_IM, 3'd1, 3'd0, 8'd0);
    mem[2] = enc(F_IM, 3'd1, 3'd0, 8'd0);
    mem[3] = enc(F_ST, 3'd1, 3'd0, 8'h40);
    mem[4] = enc(F_IM, 3'd2, 3'd0, 8'd0);
    mem[5] = enc(F_ST, 3'd2, 3'd0, 8'h41);
    mem[6] = enc(F_IM, 3'd0, 3'd0, 8'hFF);
    mem[64] = 16'hBEEF;
    run_prog(0, 60);
    check(mem[64] == 16'h0, "R5 skipped words not executed", mem[64], 0);
    check(mem[65] == 16'd5, "R5 execution resumes at branch target", mem[65], 5);

    // R10: call through inline target word, return through link register
    clear_mem(16'h0);
    mem[0]  = enc(F_IM, 3'd6, 3'd0, 8'd2);
    mem[1]  = enc(F_LD, 3'd0, 3'd0, 8'd0);
    mem[2]  = 16'd20;
    mem[3]  = enc(F_ST, 3'd1, 3'd0, 8'h40);
    mem[4]  = enc(F_ST, 3'd6, 3'd0, 8'h41);
    mem[5]  = enc(F_IM, 3'd0, 3'd0, 8'hFF);
    mem[20] = enc(F_IM, 3'd1, 3'd0, 8'd0);
    mem[21] = enc(F_IM, 3'd0, 3'd6, 8'd0);
    run_prog(2, 120);
    check(mem[64] == 16'd21, "R10 subroutine body ran at target", mem[64], 21);
    check(mem[65] == 16'd3, "R10 link holds return address", mem[65], 3);

    // R2: reset after dirty registers; ports at reset and cleared registers
    clear_mem(16'hBEEF);
    for (int k = 1; k < 8; k++) mem[k-1] = enc(F_ST, k[2:0], 3'd0, 8'(64 + k));
    mem[7] = enc(F_IM, 3'd0, 3'd0, 8'hFF);
    lat_cfg = 0;
    rst_n = 0;
    repeat (2) @(posedge clk);
    #2 rst_n = 1;
    #1;
    check(mem_rd == 1'b1, "R2 first request is a read", mem_rd, 1);
    check(mem_wr == 1'b0, "R2 no write at reset", mem_wr, 0);
    check(mem_addr == 16'h0, "R2 first fetch address", mem_addr, 0);
    repeat (60) @(posedge clk);
    #3;
    for (int k = 1; k < 8; k++)
      check(mem[64 + k] == 16'h0, "R2 register cleared by reset", mem[64 + k], 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule